// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This block connects a simple clocked request bus to an external asynchronous static memory of 524,288 bytes. Each accepted request becomes one complete memory access. The controller drives a 19-bit address and three active-low strobes: chip select, output enable and write strobe. The 8-bit data bus is split into an outgoing byte, an incoming byte and a driver enable for the tristate pad. The clock does not reach the memory, so each access is spread over a whole number of clock cycles. Each phase length is the required time in nanoseconds divided by the clock period and rounded up, with a floor of one cycle.

The sequencer has five named states. ST_IDLE keeps every strobe high and holds `ready` high. From ST_IDLE, a request with `req_we` low takes transition IDLE->RD_ACCESS, and a request with `req_we` high takes IDLE->WR_SETUP.

- **Read:** ST_RD_ACCESS holds chip select and output enable low. When its timer ends, the transition RD_ACCESS->IDLE captures the incoming byte, and `rvalid` pulses for one cycle.
- **Write:** ST_WR_SETUP lowers chip select only, so the address settles first. WR_SETUP->WR_PULSE lowers the write strobe and turns the data driver on. WR_PULSE->WR_RECOVER raises the strobe and turns the driver off, while chip select and the address stay in place. WR_RECOVER->IDLE ends the access.

Output enable stays high for every write. The controller therefore never competes with the memory for the data bus.

Top module: `asram_ctrl`

## Requirements
- R1: A request is taken on a rising edge where `req` and `ready` are both high. `ready` is low from the next cycle until the access is complete. A `req` seen while `ready` is low starts no access and does not change the latched address or data.
- R2: A read holds chip select and output enable low, with the write strobe high, for RD_CYC cycles. In the cycle after the last of these, `ready` and `rvalid` are high and `rdata` holds the byte present on `sram_dq_i`. `rvalid` is high for exactly one cycle.
- R3: A write holds chip select low with the write strobe high for SETUP_CYC cycles, then holds the write strobe low for WR_CYC cycles. It then holds chip select low with the write strobe high for TURN_CYC cycles before `ready` returns.
- R4: Output enable stays high during every write access.
- R5: `sram_dq_oe` is high in exactly the cycles where the write strobe is low, and `sram_dq_o` then carries the request's write byte. Output enable falls only when the driver was already off in the previous cycle.
- R6: `sram_addr` equals the accepted address and stays unchanged in every cycle of the access, including the write recovery cycles.
- R7: Phase lengths are computed as ceil(ns / CLK_NS), with a minimum of 1. RD_CYC comes from RD_ACCESS_NS, SETUP_CYC from ADDR_SETUP_NS, and TURN_CYC from TURN_NS. WR_CYC is the larger of the values from WR_PULSE_NS and WR_DSETUP_NS.
- R8: While reset is asserted and after its release, all three strobes are high, `sram_dq_oe` is low, `rvalid` is low and `ready` is high.
- R9: In ST_IDLE the memory is deselected: chip select is high and the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller can accept a request |
| rvalid | output | 1 | One-cycle read-data valid pulse |
| rdata | output | 8 | Captured read byte |
| sram_addr | output | 19 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_o | output | 8 | Byte toward the memory |
| sram_dq_i | input | 8 | Byte from the memory |
| sram_dq_oe | output | 1 | Data pad driver enable |

## Verification
The strobes change on the same edge that accepts a request, so the bench counts strobe cycles starting at the first falling edge after that acceptance. With phases of 3, 2, 3 and 1 cycles, a read shows output enable low at three samples and `rvalid` at the fourth sample. A write shows two setup samples, three strobe-low samples and one recovery sample, with `ready` back at the seventh sample. The bench checks each phase count, the single `rvalid` sample and the return of `ready` at those sample positions. A model of the memory flags any cycle in which it and the controller drive the bus together.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } asram_state_e;

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned CW   = 4,
    parameter int unsigned MAXV = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXV)); // R7

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int unsigned CW      = 4,
    parameter int unsigned RD_LOAD = 0,
    parameter int unsigned AS_LOAD = 0,
    parameter int unsigned WR_LOAD = 0,
    parameter int unsigned TR_LOAD = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          capture,
    output logic          ready,
    output logic          rvalid,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe
);

    asram_state_e state, state_nxt;
    logic         accept;

    assign accept = req && ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:       if (accept) state_nxt = req_we ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tmr_done) state_nxt = ST_IDLE;
            ST_WR_SETUP:   if (tmr_done) state_nxt = ST_WR_PULSE;
            ST_WR_PULSE:   if (tmr_done) state_nxt = ST_WR_RECOVER;
            ST_WR_RECOVER: if (tmr_done) state_nxt = ST_IDLE;
            default:       state_nxt = ST_IDLE;
        endcase
    end

    assign capture  = (state == ST_RD_ACCESS) && tmr_done;
    assign tmr_load = (state_nxt != state);

    always_comb begin
        tmr_val = '0;
        unique case (state_nxt)
            ST_RD_ACCESS:  tmr_val = CW'(RD_LOAD);
            ST_WR_SETUP:   tmr_val = CW'(AS_LOAD);
            ST_WR_PULSE:   tmr_val = CW'(WR_LOAD);
            ST_WR_RECOVER: tmr_val = CW'(TR_LOAD);
            default:       tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            dq_oe  <= 1'b0;
            ready  <= 1'b1;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            unique case (state_nxt)
                ST_IDLE: begin
                    ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; ready <= 1'b1;
                end
                ST_RD_ACCESS: begin
                    ce_n <= 1'b0; oe_n <= 1'b0; we_n <= 1'b1; dq_oe <= 1'b0; ready <= 1'b0;
                end
                ST_WR_SETUP, ST_WR_RECOVER: begin
                    ce_n <= 1'b0; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; ready <= 1'b0;
                end
                ST_WR_PULSE: begin
                    ce_n <= 1'b0; oe_n <= 1'b1; we_n <= 1'b0; dq_oe <= 1'b1; ready <= 1'b0;
                end
                default: begin
                    ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; ready <= 1'b1;
                end
            endcase
        end
    end

    AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R2
    AST_CAPTURE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (!oe_n && we_n && !ce_n)); // R2

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned AW            = 19,
    parameter int unsigned DW            = 8,
    parameter int unsigned CLK_NS        = 20,
    parameter int unsigned RD_ACCESS_NS  = 8,
    parameter int unsigned ADDR_SETUP_NS = 0,
    parameter int unsigned WR_PULSE_NS   = 8,
    parameter int unsigned WR_DSETUP_NS  = 5,
    parameter int unsigned TURN_NS       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [DW-1:0] sram_dq_o,
    input  logic [DW-1:0] sram_dq_i,
    output logic          sram_dq_oe
);

    localparam int unsigned RD_CYC    = ns_to_cycles(RD_ACCESS_NS, CLK_NS);
    localparam int unsigned SETUP_CYC = ns_to_cycles(ADDR_SETUP_NS, CLK_NS);
    localparam int unsigned WR_CYC    = max2(ns_to_cycles(WR_PULSE_NS, CLK_NS),
                                             ns_to_cycles(WR_DSETUP_NS, CLK_NS));
    localparam int unsigned TURN_CYC  = ns_to_cycles(TURN_NS, CLK_NS);
    localparam int unsigned MAX_CYC   = max2(max2(RD_CYC, SETUP_CYC), max2(WR_CYC, TURN_CYC));
    localparam int unsigned CW        = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic          tmr_load, tmr_done, capture;
    logic [CW-1:0] tmr_val;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          accept;

    assign accept = req && ready;

    asram_timer #(.CW(CW), .MAXV(MAX_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_fsm #(
        .CW      (CW),
        .RD_LOAD (RD_CYC - 1),
        .AS_LOAD (SETUP_CYC - 1),
        .WR_LOAD (WR_CYC - 1),
        .TR_LOAD (TURN_CYC - 1)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .capture  (capture),
        .ready    (ready),
        .rvalid   (rvalid),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .dq_oe    (sram_dq_oe)
    );

    // Request latch: address and write byte held for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read capture at the end of the access phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= sram_dq_i;
    end

    assign sram_addr = addr_q;
    assign sram_dq_o = wdata_q;
    assign rdata     = rdata_q;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |=> ($stable(addr_q) && $stable(wdata_q))); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(sram_addr)); // R6
    AST_WE_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_ce_n)); // R3
    AST_RD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> $past(!sram_dq_oe)); // R5
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R4
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(accept)) |-> (sram_ce_n && sram_we_n)); // R9

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

    localparam int EXP_RD = 3;   // ceil(50/20)
    localparam int EXP_AS = 2;   // ceil(25/20)
    localparam int EXP_WR = 3;   // max(ceil(30/20), ceil(45/20))
    localparam int EXP_TR = 1;   // ceil(3/20) floored to 1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rvalid, ce_n, oe_n, we_n, dq_oe;
    logic [7:0]  rdata, dq_o, dq_i;
    logic [18:0] sram_addr;

    int n_tests = 0, n_fail = 0, n_contend = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    asram_ctrl #(
        .CLK_NS(20), .RD_ACCESS_NS(50), .ADDR_SETUP_NS(25),
        .WR_PULSE_NS(30), .WR_DSETUP_NS(45), .TURN_NS(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .rvalid(rvalid), .rdata(rdata),
        .sram_addr(sram_addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
        .sram_we_n(we_n), .sram_dq_o(dq_o), .sram_dq_i(dq_i), .sram_dq_oe(dq_oe)
    );

    // Behavioural memory
    logic [7:0] mem [int];
    logic [7:0] mem_q = 8'h00;
    logic       mem_drv = 1'b0;

    always @(negedge clk) begin
        if (dq_oe && !ce_n && !oe_n && we_n) n_contend++;
        if (!ce_n && !we_n) mem[int'(sram_addr)] = dq_o;
        mem_drv <= !ce_n && !oe_n && we_n;
        mem_q   <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
    end

    assign dq_i = dq_oe ? dq_o : (mem_drv ? mem_q : 8'h00);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic w, input logic [18:0] a, input logic [7:0] d,
                          input logic [7:0] e, input bit poke);
        int nwe = 0, noe = 0, nce = 0, nset = 0, nrec = 0;
        int bad_oe = 0, bad_a = 0, bad_d = 0, nsamp = 0;
        logic rv = 1'b0;
        logic [7:0] rd = 8'h00;
        @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (poke) begin req_we = 1'b1; req_addr = 19'h00055; req_wdata = 8'hEE; end
        else req = 1'b0;
        for (int i = 0; i < 64; i++) begin
            nsamp++;
            if (ready) begin rv = rvalid; rd = rdata; break; end
            if (!we_n) nwe++;
            if (!oe_n) noe++;
            if (!ce_n) nce++;
            if (!ce_n && we_n && nwe == 0 && w) nset++;
            if (!ce_n && we_n && nwe > 0) nrec++;
            if (dq_oe != !we_n) bad_oe++;
            if (sram_addr != a) bad_a++;
            if (dq_oe && dq_o != d) bad_d++;
            @(negedge clk);
            if (i == 1) req = 1'b0;
        end
        if (w) begin
            chk(nset == EXP_AS, "R3 setup cycles", nset, EXP_AS);
            chk(nwe == EXP_WR, "R7 R3 strobe cycles", nwe, EXP_WR);
            chk(nrec == EXP_TR, "R3 recovery cycles", nrec, EXP_TR);
            chk(noe == 0, "R4 oe low in write", noe, 0);
            chk(bad_d == 0, "R5 write byte", bad_d, 0);
            chk(nce == EXP_AS + EXP_WR + EXP_TR, "R1 single access", nce, EXP_AS + EXP_WR + EXP_TR);
            chk(rv == 1'b0, "R2 no rvalid on write", rv, 0);
        end else begin
            chk(noe == EXP_RD, "R7 R2 read cycles", noe, EXP_RD);
            chk(nwe == 0, "R2 strobe in read", nwe, 0);
            chk(rv == 1'b1, "R2 rvalid at end", rv, 1);
            chk(rd == e, "R2 read byte", rd, e);
        end
        chk(bad_oe == 0, "R5 driver vs strobe", bad_oe, 0);
        chk(bad_a == 0, "R6 address held", bad_a, 0);
        chk(nsamp > 1, "R1 ready low while busy", nsamp, 2);
        @(negedge clk);
        chk(rvalid == 1'b0, "R2 rvalid one cycle", rvalid, 0);
        chk(ce_n && we_n && oe_n, "R9 idle deselect", {ce_n, we_n, oe_n}, 7);
    endtask

    typedef struct packed {
        logic        w;
        logic [18:0] a;
        logic [7:0]  d;
        logic [7:0]  e;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 19'h00000, 8'hA5, 8'h00},
        '{1'b1, 19'h7FFFF, 8'h3C, 8'h00},
        '{1'b1, 19'h12345, 8'hF0, 8'h00},
        '{1'b1, 19'h00055, 8'h11, 8'h00},
        '{1'b0, 19'h7FFFF, 8'h00, 8'h3C},
        '{1'b0, 19'h00000, 8'h00, 8'hA5},
        '{1'b1, 19'h12345, 8'h0F, 8'h00},
        '{1'b0, 19'h12345, 8'h00, 8'h0F},
        '{1'b0, 19'h12345, 8'h00, 8'h0F},
        '{1'b0, 19'h00055, 8'h00, 8'h11}
    };

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            chk(n_contend == 0, "R5 bus contention", n_contend, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && we_n, "R8 strobes in reset", {ce_n, oe_n, we_n}, 7);
        chk(!dq_oe && !rvalid && ready, "R8 driver/ready in reset", {dq_oe, rvalid, ready}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_oe && ready, "R8 after reset",
            {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11101);
        foreach (VECS[k]) run_op(VECS[k].w, VECS[k].a, VECS[k].d, VECS[k].e, 1'b0);
        // R1: request held high during a busy write must not start a second access
        run_op(1'b1, 19'h00100, 8'h77, 8'h00, 1'b1);
        run_op(1'b0, 19'h00055, 8'h00, 8'h11, 1'b0);
        run_op(1'b0, 19'h00100, 8'h00, 8'h77, 1'b0);
        finish_run();
    end

endmodule